// File: doc/BRIEF.md
# Staggered Round-Robin Crossbar Sequencer

This block drives the configuration of an N-port crossbar, one configuration per switching slot. It does not look at queue depths when it picks the configuration. Instead it steps through a fixed rotation of N permutations. In rotation step `t`, input `i` is paired with output `(i + t) mod N`. Over N consecutive steps every input meets every output exactly once, so each input-output pair is guaranteed one slot in N whatever the traffic.

The only use the block makes of queue state is to mask grants. A grant for input `i` is raised only when the virtual output queue from `i` to its current target is non-empty. A pair whose queue is empty simply loses its slot, and no other pair is given that slot. This makes the schedule intentionally non-maximal.

A concurrent mode feeds K pipelined space elements. Each slot goes to element `slot mod K`, and the rotation moves forward by one step only after every element has had its turn, which takes K slots. A full cycle in this mode therefore covers K·N slots.

Top module: `srr_sequencer`

## Requirements
- R1: A synchronous reset clears every selected-output index, the grant mask and the element index to zero, and sets the rotation step to zero. The first slot after reset therefore pairs input `i` with output `i`.
- R2: In normal mode (`conc_i` low), a strobe sampled at a rising edge loads `sel_o` on that same edge with output `(i + t) mod N` for input `i`. Here `t` is the rotation step, and the step then advances by one, wrapping from N-1 to 0.
- R3: After every strobe, the N indices in `sel_o` are pairwise distinct, so they form a permutation. `sel_o` packs input `i` at bits `[i*IW +: IW]`, with `IW = clog2(N)`.
- R4: After a strobe, `gnt_o[i]` is 1 exactly when request bit `req_i[i*N + j]` was 1 at the strobe, where `j` is the index then loaded for input `i`. Bit `i*N + j` means that the queue from input `i` to output `j` is non-empty.
- R5: When the target queue of an input is empty, its grant stays low and its index still shows the rotation target. Requests to other outputs do not redirect it.
- R6: `gnt_o` is all zero in every cycle that does not directly follow a strobe.
- R7: In concurrent mode, successive strobes give `elem_o` the values 0, 1, …, K-1 in turn, and the rotation step advances only on the strobe that wraps the element counter.
- R8: A strobe in normal mode gives `elem_o = 0` and clears the element counter. A later switch back to concurrent mode therefore starts at element 0.
- R9: Without a strobe, `sel_o` and `elem_o` hold their values.
- R10: A reset during operation returns the rotation to step 0 and the element counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_i | input | 1 | Slot strobe; one configuration is issued per strobe |
| conc_i | input | 1 | 1 = concurrent mode across K space elements |
| req_i | input | N*N | Queue non-empty bitmap; bit i*N+j is the queue from input i to output j |
| sel_o | output | N*IW | Selected output index per input, packed by input |
| gnt_o | output | N | Grant valid per input, one cycle after a strobe |
| elem_o | output | KW | Space element served by this slot (0 in normal mode) |

## Verification
The bench builds the block with N = 4 and K = 2. With these values, the full normal-mode rotation and its wrap back to step 0 fit in a handful of slots, and so does a concurrent cycle in which the rotation pauses for a second element. Request patterns are chosen so that masked grants can be told apart from traffic that sits on non-target outputs. Leaving concurrent mode halfway through an element pair and resetting partway through the rotation are both exercised, which checks that the counters clear properly.

// File: rtl/srr_pkg.sv
package srr_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/srr_phase.sv
module srr_phase #(
  parameter int N = 4,
  parameter int K = 2,
  localparam int IW = srr_pkg::idx_w(N),
  localparam int KW = srr_pkg::idx_w(K)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_i,
  input  logic          conc_i,
  output logic [IW-1:0] off_o,
  output logic [KW-1:0] elem_o
);
  localparam logic [IW-1:0] OFF_LAST  = IW'(N - 1);
  localparam logic [KW-1:0] ELEM_LAST = KW'(K - 1);

  logic step;

  // the rotation moves on every normal slot, or once per K concurrent slots
  always_comb begin
    step = 1'b0;
    if (slot_i) begin
      step = conc_i ? (elem_o == ELEM_LAST) : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_o  <= '0;
      elem_o <= '0;
    end else begin
      if (step) begin
        off_o <= (off_o == OFF_LAST) ? '0 : off_o + IW'(1);
      end
      if (slot_i) begin
        if (!conc_i || elem_o == ELEM_LAST) begin
          elem_o <= '0;
        end else begin
          elem_o <= elem_o + KW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/srr_rotator.sv
module srr_rotator #(
  parameter int N = 4,
  localparam int IW = srr_pkg::idx_w(N)
) (
  input  logic [IW-1:0]   off_i,
  output logic [N*IW-1:0] tgt_o
);
  localparam logic [IW:0] MODV = (IW+1)'(N);

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [IW:0] sum;
    always_comb begin
      sum = {1'b0, off_i} + (IW+1)'(i);
      if (sum >= MODV) begin
        sum = sum - MODV;
      end
    end
    assign tgt_o[i*IW +: IW] = sum[IW-1:0];
  end
endmodule

// File: rtl/srr_mask.sv
module srr_mask #(
  parameter int N = 4,
  localparam int IW = srr_pkg::idx_w(N)
) (
  input  logic [N*N-1:0]  req_i,
  input  logic [N*IW-1:0] tgt_i,
  output logic [N-1:0]    hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_in
    logic [N-1:0]  row;
    logic [IW-1:0] tgt;
    assign row      = req_i[i*N +: N];
    assign tgt      = tgt_i[i*IW +: IW];
    assign hit_o[i] = row[tgt];
  end
endmodule

// File: rtl/srr_sequencer.sv
module srr_sequencer #(
  parameter int N = 4,
  parameter int K = 2,
  localparam int IW = srr_pkg::idx_w(N),
  localparam int KW = srr_pkg::idx_w(K)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_i,
  input  logic            conc_i,
  input  logic [N*N-1:0]  req_i,
  output logic [N*IW-1:0] sel_o,
  output logic [N-1:0]    gnt_o,
  output logic [KW-1:0]   elem_o
);
  logic [IW-1:0]   off;
  logic [KW-1:0]   elem_cur;
  logic [N*IW-1:0] tgt;
  logic [N-1:0]    hit;

  srr_phase #(.N(N), .K(K)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .slot_i (slot_i),
    .conc_i (conc_i),
    .off_o  (off),
    .elem_o (elem_cur)
  );

  srr_rotator #(.N(N)) u_rot (
    .off_i (off),
    .tgt_o (tgt)
  );

  srr_mask #(.N(N)) u_mask (
    .req_i (req_i),
    .tgt_i (tgt),
    .hit_o (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      gnt_o  <= '0;
      elem_o <= '0;
    end else begin
      gnt_o <= slot_i ? hit : '0;
      if (slot_i) begin
        sel_o  <= tgt;
        elem_o <= conc_i ? elem_cur : '0;
      end
    end
  end
endmodule

// File: rtl/srr_sequencer_chk.sv
module srr_sequencer_chk #(
  parameter int N = 4,
  parameter int K = 2,
  localparam int IW = srr_pkg::idx_w(N),
  localparam int KW = srr_pkg::idx_w(K)
) (
  input logic            clk,
  input logic            rst,
  input logic            slot_i,
  input logic            conc_i,
  input logic [N*N-1:0]  req_i,
  input logic [N*IW-1:0] sel_o,
  input logic [N-1:0]    gnt_o,
  input logic [KW-1:0]   elem_o
);
  logic [N*N-1:0] req_q;
  logic           distinct;

  always_ff @(posedge clk) req_q <= req_i;

  always_comb begin
    distinct = 1'b1;
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        if (sel_o[a*IW +: IW] == sel_o[b*IW +: IW]) distinct = 1'b0;
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sel_o == '0 && gnt_o == '0 && elem_o == '0));

  a_r3_permutation: assert property (@(posedge clk) disable iff (rst)
    slot_i |=> distinct);

  a_r6_no_idle_grant: assert property (@(posedge clk) disable iff (rst)
    !slot_i |=> gnt_o == '0);

  a_r8_normal_elem_zero: assert property (@(posedge clk) disable iff (rst)
    (slot_i && !conc_i) |=> elem_o == '0);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !slot_i |=> ($stable(sel_o) && $stable(elem_o)));

  for (genvar i = 0; i < N; i++) begin : g_gnt
    logic [N-1:0]  row_q;
    logic [IW-1:0] sel_i;
    assign row_q = req_q[i*N +: N];
    assign sel_i = sel_o[i*IW +: IW];
    a_r4_grant_mask: assert property (@(posedge clk) disable iff (rst)
      slot_i |=> gnt_o[i] == row_q[sel_i]);
  end
endmodule

bind srr_sequencer srr_sequencer_chk #(.N(N), .K(K)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .slot_i (slot_i),
  .conc_i (conc_i),
  .req_i  (req_i),
  .sel_o  (sel_o),
  .gnt_o  (gnt_o),
  .elem_o (elem_o)
);

// File: tb/srr_sequencer_test.sv
`timescale 1ns/1ps
module srr_sequencer_test;
  localparam int N = 4;
  localparam int K = 2;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_i = 1'b0;
  logic        conc_i = 1'b0;
  logic [15:0] req_i = '0;
  logic [7:0]  sel_o;
  logic [3:0]  gnt_o;
  logic [0:0]  elem_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  srr_sequencer #(.N(N), .K(K)) uut (
    .clk(clk), .rst(rst), .slot_i(slot_i), .conc_i(conc_i),
    .req_i(req_i), .sel_o(sel_o), .gnt_o(gnt_o), .elem_o(elem_o)
  );

  // {conc, req, expected sel, expected gnt, expected elem}
  // sel per step: 0->E4, 1->39, 2->4E, 3->93
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 8'hE4, 4'hF, 1'b0},  // R2 step 0
    {1'b0, 16'h0000, 8'h39, 4'h0, 1'b0},  // R5 all empty
    {1'b0, 16'h0125, 8'h4E, 4'h5, 1'b0},  // R4/R5 off-target bits ignored
    {1'b0, 16'h4010, 8'h93, 4'hA, 1'b0},  // R4
    {1'b0, 16'hFFFF, 8'hE4, 4'hF, 1'b0},  // R2 wrap
    {1'b1, 16'hFFFF, 8'h39, 4'hF, 1'b0},  // R7 elem 0
    {1'b1, 16'h0000, 8'h39, 4'h0, 1'b1},  // R7 elem 1, same step
    {1'b1, 16'hFFFF, 8'h4E, 4'hF, 1'b0},  // R7 step advanced
    {1'b1, 16'h2000, 8'h4E, 4'h8, 1'b1},  // R7/R4
    {1'b1, 16'hFFFF, 8'h93, 4'hF, 1'b0},  // R7
    {1'b0, 16'hFFFF, 8'h93, 4'hF, 1'b0},  // R8 leave mid-pair
    {1'b1, 16'hFFFF, 8'hE4, 4'hF, 1'b0}   // R8 restart at elem 0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic c, input logic [15:0] r);
    @(negedge clk);
    conc_i = c;
    req_i  = r;
    slot_i = 1'b1;
    @(negedge clk);
    slot_i = 1'b0;
  endtask

  initial begin : watchdog
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] sel_keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sel", 32'(sel_o), 32'h00);
    chk("R1 gnt", 32'(gnt_o), 32'h0);
    chk("R1 elem", 32'(elem_o), 32'h0);

    for (int v = 0; v < NV; v++) begin
      strobe(VEC[v][29], VEC[v][28:13]);
      chk($sformatf("R2/R4/R7 vec%0d sel", v), 32'(sel_o), 32'(VEC[v][12:5]));
      chk($sformatf("R4/R5 vec%0d gnt", v), 32'(gnt_o), 32'(VEC[v][4:1]));
      chk($sformatf("R7/R8 vec%0d elem", v), 32'(elem_o), 32'(VEC[v][0]));
      sel_keep = sel_o;
      req_i = 16'hFFFF;
      @(negedge clk);
      chk($sformatf("R6 vec%0d idle gnt", v), 32'(gnt_o), 32'h0);
      chk($sformatf("R9 vec%0d hold sel", v), 32'(sel_o), 32'(sel_keep));
    end

    // R10: advance to a nonzero step and element, then reset mid-run
    strobe(1'b1, 16'hFFFF);
    chk("R7 elem after conc strobe", 32'(elem_o), 32'h1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 sel after mid reset", 32'(sel_o), 32'h00);
    strobe(1'b1, 16'hFFFF);
    chk("R10 sel step 0 after reset", 32'(sel_o), 32'hE4);
    chk("R10 elem 0 after reset", 32'(elem_o), 32'h0);

    // R3: one full normal rotation, each pair exactly once
    begin
      logic [15:0] seen;
      seen = '0;
      for (int s = 0; s < N; s++) begin
        strobe(1'b0, 16'hFFFF);
        for (int i = 0; i < N; i++) seen[i*N + int'(sel_o[i*2 +: 2])] = 1'b1;
      end
      chk("R3 all pairs covered in N slots", 32'(seen), 32'hFFFF);
    end

    // R6/R9: long idle with changing requests
    sel_keep = sel_o;
    for (int s = 0; s < 5; s++) begin
      req_i = 16'(s * 16'h1357);
      @(negedge clk);
      chk("R6 idle gnt", 32'(gnt_o), 32'h0);
    end
    chk("R9 idle sel hold", 32'(sel_o), 32'(sel_keep));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule